// File: doc/BRIEF.md
# Read Prefetch Boundary Controller

This block sits beside the target-side engine of a bus bridge and decides how many dwords of read data it fetches for one forwarded read. A start pulse captures the command, the prefetchable-space flag, the cache line size, the flow-through flag and the starting dword address. From these it works out how far the fetch may run. It then follows each dword the target accepts and raises a registered stop when the fetch must end.

A fetch ends in one of four ways. The last dword before an aligned boundary is accepted, the target disconnects, the read queue fills (only in the unbounded multiple-line case), or the initiator releases its frame in flow-through mode. `bound_o` tells the engine whether the stop came from the aligned boundary. When the initiator ends the transaction, `flush_o` pulses for one cycle so that any leftover prefetched data can be dropped. The block then returns to idle.

Top module: `rd_prefetch_bound_ctrl`

## Requirements
- R1: Command codes are 0 configuration read, 1 I/O read, 2 memory read, 3 memory read line, 4 memory read multiple. Codes 0, 1, 5, 6 and 7, and code 2 with `pref_i` low, fetch exactly one dword.
- R2: Code 2 with `pref_i` high and a cache line size of 1, 2, 4 or 8 fetches up to the next multiple of the line size above the start address (start 6, size 4 gives 2 dwords).
- R3: Codes 2 (prefetchable) and 3 with a cache line size outside {1,2,4,8}, zero included, fetch up to the next 16-dword aligned address.
- R4: Code 3 is always prefetchable. With a legal line size it fetches up to the next line boundary.
- R5: Code 4 with a legal line size fetches up to the second line boundary above the start (start 1, size 4 gives 7 dwords).
- R6: Code 4 with an illegal line size fetches without an address limit until `q_full_i`. A dword accepted in that same cycle counts, and `bound_o` stays low.
- R7: With `flow_i` high, prefetchable reads (those of R2 to R6) fetch up to the next 1024-dword (4 KB) aligned address, or stop early with `bound_o` low on `frame_end_i`.
- R8: `tgt_disc_i` during a fetch stops it with `bound_o` low. If it comes in the same cycle as the accept of the last dword before the boundary, `bound_o` is high.
- R9: `ini_end_i` while fetching or stopped returns the block to idle and pulses `flush_o` high for exactly one cycle after that edge. Any accept in that cycle is ignored.
- R10: `next_addr_o` equals the start address plus the number of dwords accepted while fetching. It changes only on an accept.
- R11: `go_o` is high from the cycle after a start until the stop. `stop_o` rises in the cycle after the edge that accepted the final dword. The two are never high together.
- R12: After reset `go_o`, `stop_o`, `bound_o`, `flush_o` are low and `next_addr_o` is zero.
- R13: `start_i` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a forwarded read (captured when idle) |
| cmd_i | input | 3 | Read command code |
| pref_i | input | 1 | Target space is prefetchable |
| cls_i | input | 8 | Cache line size in dwords |
| flow_i | input | 1 | Flow-through mode |
| addr_i | input | AW (30) | Start dword address |
| acc_i | input | 1 | Target accepted one dword this cycle |
| tgt_disc_i | input | 1 | Target disconnect |
| q_full_i | input | 1 | Read data queue full |
| frame_end_i | input | 1 | Initiator released frame (flow-through) |
| ini_end_i | input | 1 | Initiator finished the transaction |
| go_o | output | 1 | Keep prefetching |
| stop_o | output | 1 | Stop prefetching |
| bound_o | output | 1 | Stop caused by the aligned boundary |
| flush_o | output | 1 | Discard leftover prefetched data |
| next_addr_o | output | AW (30) | Next dword address to fetch |

## Verification
The bench aims at misaligned starts. A block that measured from zero instead of from the start address would fetch a full line where only one or two dwords remain. It also aims at line size 8 and at illegal sizes such as 0, 3, 5 and 16. A wrong legality decode or a wrong mask would pick the wrong rule or miscount by a few dwords. Further cases are a disconnect coinciding with the last dword, which a wrong priority would report as a non-boundary stop, and a queue-full or frame-end accept that might be dropped. Accept gaps and a start issued while stopped check that the address counter only moves on accepts and that a stray start does not reload it.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  typedef enum logic [2:0] {
    CMD_CFG_RD      = 3'd0,
    CMD_IO_RD       = 3'd1,
    CMD_MEM_RD      = 3'd2,
    CMD_MEM_RD_LINE = 3'd3,
    CMD_MEM_RD_MULT = 3'd4
  } rd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } pf_state_e;

  typedef struct packed {
    logic unlim;
    logic ft;
  } pf_mode_t;
endpackage

// File: rtl/rpb_limit_calc.sv
module rpb_limit_calc
  import rpb_pkg::*;
#(
  parameter int AW    = 30,
  parameter int FT_DW = 1024,
  parameter int FB_DW = 16,
  parameter int RW    = $clog2(FT_DW) + 1
) (
  input  logic [2:0]    cmd_i,
  input  logic          pref_i,
  input  logic [7:0]    cls_i,
  input  logic          flow_i,
  input  logic [AW-1:0] addr_i,
  output logic [RW-1:0] rem_o,
  output pf_mode_t      mode_o
);
  localparam int FT_LG = $clog2(FT_DW);
  localparam int FB_LG = $clog2(FB_DW);

  logic          cls_legal, is_pf;
  logic [2:0]    cls_mask;
  logic [RW-1:0] cls_val, cls_off, ft_off, fb_off;

  always_comb begin
    cls_legal = (cls_i == 8'd1) || (cls_i == 8'd2) || (cls_i == 8'd4) || (cls_i == 8'd8);
    is_pf     = ((cmd_i == CMD_MEM_RD) && pref_i) || (cmd_i == CMD_MEM_RD_LINE) ||
                (cmd_i == CMD_MEM_RD_MULT);
    cls_mask  = cls_i[2:0] - 3'd1;   // size 8 wraps to mask 7
    cls_val   = RW'(cls_i[3:0]);
    cls_off   = RW'(addr_i[2:0] & cls_mask);
    ft_off    = RW'(addr_i[FT_LG-1:0]);
    fb_off    = RW'(addr_i[FB_LG-1:0]);

    mode_o.ft    = flow_i && is_pf;
    mode_o.unlim = 1'b0;
    if (!is_pf) begin
      rem_o = RW'(1);
    end else if (flow_i) begin
      rem_o = RW'(FT_DW) - ft_off;
    end else if (cmd_i == CMD_MEM_RD_MULT) begin
      if (cls_legal) begin
        rem_o = (cls_val << 1) - cls_off;
      end else begin
        rem_o        = RW'(1);
        mode_o.unlim = 1'b1;
      end
    end else if (cls_legal) begin
      rem_o = cls_val - cls_off;
    end else begin
      rem_o = RW'(FB_DW) - fb_off;
    end
  end
endmodule

// File: rtl/rpb_addr_track.sv
module rpb_addr_track #(
  parameter int AW = 30,
  parameter int RW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [RW-1:0] load_rem_i,
  input  logic          acc_en_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [RW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_o <= load_addr_i;
      rem_q  <= load_rem_i;
    end else if (acc_en_i) begin
      addr_o <= addr_o + AW'(1);
      rem_q  <= rem_q - RW'(1);
    end
  end

  assign last_o = (rem_q == RW'(1));

  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !load_i) |=> $stable(addr_o));
  p_addr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !load_i) |=> (addr_o == $past(addr_o) + AW'(1)));
endmodule

// File: rtl/rpb_stop_fsm.sv
module rpb_stop_fsm
  import rpb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  pf_mode_t mode_i,
  input  logic     acc_i,
  input  logic     last_i,
  input  logic     tgt_disc_i,
  input  logic     q_full_i,
  input  logic     frame_end_i,
  input  logic     ini_end_i,
  output logic     load_o,
  output logic     acc_en_o,
  output logic     go_o,
  output logic     stop_o,
  output logic     bound_o,
  output logic     flush_o
);
  pf_state_e state_q, state_d;
  pf_mode_t  mode_q;
  logic      bound_d, flush_d, end_hit, early;

  always_comb begin
    load_o   = (state_q == ST_IDLE) && start_i;
    acc_en_o = (state_q == ST_FETCH) && acc_i && !ini_end_i;
    end_hit  = acc_en_o && last_i && !mode_q.unlim;
    early    = tgt_disc_i || (mode_q.unlim && q_full_i) || (mode_q.ft && frame_end_i);
    state_d  = state_q;
    bound_d  = bound_o;
    flush_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_FETCH;
        bound_d = 1'b0;
      end
      ST_FETCH: if (ini_end_i) begin
        state_d = ST_IDLE;
        flush_d = 1'b1;
        bound_d = 1'b0;
      end else if (end_hit) begin
        state_d = ST_DONE;
        bound_d = 1'b1;
      end else if (early) begin
        state_d = ST_DONE;
      end
      ST_DONE: if (ini_end_i) begin
        state_d = ST_IDLE;
        flush_d = 1'b1;
        bound_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      bound_o <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      state_q <= state_d;
      bound_o <= bound_d;
      flush_o <= flush_d;
      if (load_o) mode_q <= mode_i;
    end
  end

  assign go_o   = (state_q == ST_FETCH);
  assign stop_o = (state_q == ST_DONE);

  p_go_stop_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_o && stop_o));
  p_flush_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  p_bound_with_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_o |-> stop_o);
  p_start_enters_fetch_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> go_o);
  p_stop_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !ini_end_i) |=> stop_o);
endmodule

// File: rtl/rd_prefetch_bound_ctrl.sv
module rd_prefetch_bound_ctrl
  import rpb_pkg::*;
#(
  parameter int AW    = 30,
  parameter int FT_DW = 1024,
  parameter int FB_DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    cmd_i,
  input  logic          pref_i,
  input  logic [7:0]    cls_i,
  input  logic          flow_i,
  input  logic [AW-1:0] addr_i,
  input  logic          acc_i,
  input  logic          tgt_disc_i,
  input  logic          q_full_i,
  input  logic          frame_end_i,
  input  logic          ini_end_i,
  output logic          go_o,
  output logic          stop_o,
  output logic          bound_o,
  output logic          flush_o,
  output logic [AW-1:0] next_addr_o
);
  localparam int RW = $clog2(FT_DW) + 1;

  logic [RW-1:0] calc_rem;
  pf_mode_t      calc_mode;
  logic          load, acc_en, last;

  rpb_limit_calc #(.AW(AW), .FT_DW(FT_DW), .FB_DW(FB_DW), .RW(RW)) i_calc (
    .cmd_i  (cmd_i),
    .pref_i (pref_i),
    .cls_i  (cls_i),
    .flow_i (flow_i),
    .addr_i (addr_i),
    .rem_o  (calc_rem),
    .mode_o (calc_mode)
  );

  rpb_addr_track #(.AW(AW), .RW(RW)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (addr_i),
    .load_rem_i  (calc_rem),
    .acc_en_i    (acc_en),
    .addr_o      (next_addr_o),
    .last_o      (last)
  );

  rpb_stop_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (calc_mode),
    .acc_i       (acc_i),
    .last_i      (last),
    .tgt_disc_i  (tgt_disc_i),
    .q_full_i    (q_full_i),
    .frame_end_i (frame_end_i),
    .ini_end_i   (ini_end_i),
    .load_o      (load),
    .acc_en_o    (acc_en),
    .go_o        (go_o),
    .stop_o      (stop_o),
    .bound_o     (bound_o),
    .flush_o     (flush_o)
  );

  p_calc_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> (calc_rem != '0));
endmodule

// File: tb/test_rd_prefetch_bound_ctrl.sv
module test_rd_prefetch_bound_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, pref = 0, flow = 0, acc = 0, disc = 0, qfull = 0, fend = 0, iend = 0;
  logic [2:0]  cmd = 0;
  logic [7:0]  cls = 0;
  logic [29:0] addr = 0;
  logic        go, stop, bound, flush;
  logic [29:0] naddr;
  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R12";

  always #2.5 clk = ~clk;

  rd_prefetch_bound_ctrl i_rd_prefetch_bound_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .pref_i(pref), .cls_i(cls),
    .flow_i(flow), .addr_i(addr), .acc_i(acc), .tgt_disc_i(disc), .q_full_i(qfull),
    .frame_end_i(fend), .ini_end_i(iend), .go_o(go), .stop_o(stop), .bound_o(bound),
    .flush_o(flush), .next_addr_o(naddr));

  // behavioural reference
  int m_st, m_rem;
  logic m_unlim, m_ft, m_bound, m_flush;
  logic [29:0] m_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_addr = 0; m_bound = 0; m_flush = 0; m_unlim = 0; m_ft = 0;
    end else begin
      bit pf, legal, last;
      int a;
      m_flush = 0;
      case (m_st)
        0: if (start) begin
          pf    = (cmd == 2 && pref) || cmd == 3 || cmd == 4;
          legal = (cls == 1 || cls == 2 || cls == 4 || cls == 8);
          a     = int'(addr);
          m_unlim = 0;
          m_ft    = flow && pf;
          if (!pf) m_rem = 1;
          else if (flow) m_rem = 1024 - a % 1024;
          else if (cmd == 4) begin
            if (legal) m_rem = 2 * cls - a % cls;
            else m_unlim = 1;
          end else if (legal) m_rem = cls - a % cls;
          else m_rem = 16 - a % 16;
          m_st = 1; m_bound = 0; m_addr = addr;
        end
        1: if (iend) begin
          m_st = 0; m_flush = 1; m_bound = 0;
        end else begin
          last = !m_unlim && m_rem == 1;
          if (acc) begin m_addr = m_addr + 1; m_rem = m_rem - 1; end
          if (acc && last) begin m_st = 2; m_bound = 1; end
          else if (disc || (m_unlim && qfull) || (m_ft && fend)) m_st = 2;
        end
        2: if (iend) begin m_st = 0; m_flush = 1; m_bound = 0; end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "model go_o", int'(go), int'(m_st == 1));
    chk(cur_req, "model stop_o", int'(stop), int'(m_st == 2));
    chk(cur_req, "model bound_o", int'(bound), int'(m_bound));
    chk(cur_req, "model flush_o", int'(flush), int'(m_flush));
    chk(cur_req, "model next_addr_o", int'(naddr), int'(m_addr));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input string req, input logic [2:0] c, input logic p, input logic [7:0] cl,
                     input logic f, input logic [29:0] a, input bit gaps, input int disc_at,
                     input int qf_at, input int fe_at, input int ie_at, input int exp_n,
                     input logic exp_b);
    bit aborted = 0;
    cur_req = req;
    @(negedge clk);
    cmd = c; pref = p; cls = cl; flow = f; addr = a; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 3000; i++) begin
      acc = gaps ? (i % 2 == 0) : 1'b1;
      disc = (i == disc_at); qfull = (i == qf_at); fend = (i == fe_at); iend = (i == ie_at);
      @(negedge clk);
      if (i == ie_at) begin aborted = 1; break; end
      if (stop) break;
    end
    acc = 0; disc = 0; qfull = 0; fend = 0; iend = 0;
    if (aborted) begin
      chk({req, " R9"}, "flush on early end", int'(flush), 1);
      chk({req, " R9"}, "idle after early end", int'(go || stop), 0);
    end else begin
      chk(req, "dwords fetched", int'(naddr - a), exp_n);
      chk(req, "bound_o", int'(bound), int'(exp_b));
      chk(req, "stop_o", int'(stop), 1);
      iend = 1;
      @(negedge clk);
      iend = 0;
      chk("R9", "flush after end", int'(flush), 1);
      @(negedge clk);
      chk("R9", "flush single", int'(flush), 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "go_o reset", int'(go), 0);
    chk("R12", "stop_o reset", int'(stop), 0);
    chk("R12", "bound_o reset", int'(bound), 0);
    chk("R12", "flush_o reset", int'(flush), 0);
    chk("R12", "next_addr_o reset", int'(naddr), 0);
    rst_n = 1;
    @(negedge clk);
    run("R1 cfg",            3'd0, 1, 8'd8,  0, 30'd5,    0, -1, -1, -1, -1, 1,  1);
    run("R1 io",             3'd1, 1, 8'd4,  0, 30'd9,    0, -1, -1, -1, -1, 1,  1);
    run("R1 nonpref ft",     3'd2, 0, 8'd4,  1, 30'd3,    0, -1, -1, -1, -1, 1,  1);
    run("R1 code6",          3'd6, 1, 8'd4,  0, 30'd0,    0, -1, -1, -1, -1, 1,  1);
    run("R2 cls4 a6",        3'd2, 1, 8'd4,  0, 30'd6,    0, -1, -1, -1, -1, 2,  1);
    run("R2 R10 cls8 gaps",  3'd2, 1, 8'd8,  0, 30'd0,    1, -1, -1, -1, -1, 8,  1);
    run("R3 cls3 a5",        3'd2, 1, 8'd3,  0, 30'd5,    0, -1, -1, -1, -1, 11, 1);
    run("R3 cls0 a16",       3'd2, 1, 8'd0,  0, 30'd16,   0, -1, -1, -1, -1, 16, 1);
    run("R4 line cls2 a7",   3'd3, 0, 8'd2,  0, 30'd7,    0, -1, -1, -1, -1, 1,  1);
    run("R3 line cls16 a3",  3'd3, 0, 8'd16, 0, 30'd3,    0, -1, -1, -1, -1, 13, 1);
    run("R5 mult cls4 a1",   3'd4, 0, 8'd4,  0, 30'd1,    0, -1, -1, -1, -1, 7,  1);
    run("R5 R10 mult cls8",  3'd4, 0, 8'd8,  0, 30'd8,    1, -1, -1, -1, -1, 16, 1);
    run("R6 mult cls5 qf",   3'd4, 0, 8'd5,  0, 30'd2,    0, -1, 20, -1, -1, 21, 0);
    run("R7 ft line a1020",  3'd3, 0, 8'd4,  1, 30'd1020, 0, -1, -1, -1, -1, 4,  1);
    run("R7 ft mult fend",   3'd4, 0, 8'd4,  1, 30'd0,    0, -1, -1, 9,  -1, 10, 0);
    run("R8 disc early",     3'd2, 1, 8'd8,  0, 30'd0,    0, 1,  -1, -1, -1, 2,  0);
    run("R8 disc on last",   3'd2, 1, 8'd4,  0, 30'd2,    0, 1,  -1, -1, -1, 2,  1);
    run("R9 abort fetch",    3'd4, 0, 8'd8,  0, 30'd0,    0, -1, -1, -1, 3,  0,  0);
    // R13: start while stopped is ignored
    cur_req = "R13";
    @(negedge clk);
    cmd = 3'd0; pref = 0; cls = 8'd4; flow = 0; addr = 30'd40; start = 1;
    @(negedge clk);
    start = 0; acc = 1;
    @(negedge clk);
    acc = 0; addr = 30'd77; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk("R13", "stop held", int'(stop), 1);
    chk("R13", "addr not reloaded", int'(naddr), 41);
    chk("R11", "go low when stopped", int'(go), 0);
    iend = 1;
    @(negedge clk);
    iend = 0;
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule